// File: doc/BRIEF.md
# Serial Pixel Frame Alignment Tracker

This block sits on the receive side of a single-bit serial pixel link. It samples one bit per clock and cuts the stream into 24-bit frames. Each frame holds one pixel of 18 color bits, the three timing controls (vertical sync, horizontal sync, data enable), a 2-bit rolling sequence count and an odd-parity bit. The link has no line coding. The only alignment aid is the sequence count: the transmitter adds one to it on every frame. The tracker watches that count and keeps the frame boundary in place. When the count stops advancing it gives up the current boundary. It then moves the boundary one bit at a time until the count advances cleanly again.

The tracker is built around one state machine with four states. LOCKED is normal operation. SUSPECT means one sequence miss has been seen while locked. HUNT means the boundary is being moved to a new candidate. CONFIRM means a candidate boundary is being checked before lock is declared.

The transitions are:
- LOCKED→SUSPECT on a miss.
- SUSPECT→LOCKED on a good step.
- SUSPECT→HUNT on a second miss in a row.
- HUNT→HUNT on a miss, with another one-bit slip.
- HUNT→CONFIRM on the first good step at the candidate boundary.
- CONFIRM→LOCKED on the fourth good step.
- CONFIRM→HUNT on a miss.

Accepted frames leave the block as a one-cycle valid pulse. The pulse carries the pixel, the timing bits and a parity-error flag.

Top module: `frm_align_tracker`

## Requirements
- R1: One bit is sampled per clock and the first bit sampled after reset is the first bit of a 24-bit frame. Frame bits are sent MSB first with this layout, counting bit 23 as the first bit: bits 23..6 pixel (red 23..18, green 17..12, blue 11..6), bit 5 VS, bit 4 HS, bit 3 DE, bits 2..1 sequence count (bit 2 high), bit 0 parity.
- R2: For each accepted frame, pix_valid is high for exactly one clock. In that clock the pixel and VS/HS/DE outputs carry the frame's payload bits unchanged, and frames come out in arrival order.
- R3: A frame is a good step when its sequence count equals the reference plus one modulo 4, so 3 followed by 0 is a good step.
- R4: Reset leaves the block in LOCKED with locked high and the boundary at offset 0. The first frame after reset, and the first frame after every slip, only loads the reference and is never counted as a miss.
- R5: par_err is high together with pix_valid when the XOR of all 24 bits of the frame is 0, which breaks odd parity.
- R6: A parity error alone changes neither the lock state nor the output of the frame.
- R7: A single miss while LOCKED moves to SUSPECT and leaves locked high. The frame is still output, and the reference advances to the expected value, so a correct next frame returns the block to LOCKED.
- R8: Two consecutive misses drop locked (SUSPECT→HUNT), and the second missed frame is not output.
- R9: While locked is low, pix_valid stays low. The pixel, timing and parity outputs are zero whenever pix_valid is low.
- R10: On entry to HUNT and on every miss inside HUNT or CONFIRM, the frame boundary is delayed by exactly one bit, so the offset advances by one modulo 24.
- R11: Lock is declared again only after 4 consecutive good steps at one offset (after the reference frame). The frame that completes the fourth step is the first one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit, one per clock |
| pix_rgb | output | 18 | Pixel color bits of the accepted frame, red in the top six |
| pix_vs | output | 1 | Vertical sync bit of the accepted frame |
| pix_hs | output | 1 | Horizontal sync bit of the accepted frame |
| pix_de | output | 1 | Data enable bit of the accepted frame |
| pix_valid | output | 1 | One-cycle pulse per accepted frame |
| par_err | output | 1 | Odd-parity failure of the accepted frame |
| locked | output | 1 | High in LOCKED and SUSPECT |

## Verification
Some properties are checked by assertions on every cycle:
- a valid pulse only occurs under lock;
- the outputs are zero between pulses;
- lock only falls right after a miss;
- a slip only occurs while unlocked and lasts one cycle;
- lock only rises after the required run of good steps since the last slip.

Other behaviour can only be shown by the bench's scenarios. These cover the exact bit layout, the pass-through of data and the wrap of the count from 3 to 0. They also cover the parity flag, recovery from a single glitch and the drop on a double miss. The last scenario inserts one extra bit into the stream. It then checks that exactly one slip restores alignment and that the first frame output after relock is the fifth frame at the new offset.

// File: rtl/frm_pkg.sv
package frm_pkg;

    // Fixed field sizes inside one frame
    localparam int CTRL_BITS = 3;
    localparam int SEQ_BITS  = 2;
    localparam int PAR_BITS  = 1;
    localparam int OVH_BITS  = CTRL_BITS + SEQ_BITS + PAR_BITS;

    // Bit positions counted from the last bit of the frame
    localparam int POS_PE  = 0;
    localparam int POS_F0  = 1;
    localparam int POS_F1  = 2;
    localparam int POS_DE  = 3;
    localparam int POS_HS  = 4;
    localparam int POS_VS  = 5;
    localparam int PIX_LSB = OVH_BITS;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_SUSPECT,
        ST_HUNT,
        ST_CONFIRM
    } lock_state_t;

endpackage

// File: rtl/frm_slicer.sv
module frm_slicer #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_in,
    input  logic               slip,
    output logic [FRAME_W-1:0] frame_q,
    output logic               frame_stb
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic               at_end;

    assign at_end = (bit_cnt == LAST) && !slip;

    // Bit position counter; a slip holds it for one clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (slip) begin
            bit_cnt <= bit_cnt;
        end else if (bit_cnt == LAST) begin
            bit_cnt <= '0;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            frame_q   <= '0;
            frame_stb <= 1'b0;
        end else begin
            shift_q   <= {shift_q[FRAME_W-2:0], ser_in};
            frame_stb <= at_end;
            if (at_end) begin
                frame_q <= {shift_q[FRAME_W-2:0], ser_in};
            end
        end
    end

endmodule

// File: rtl/frm_seq_check.sv
module frm_seq_check #(
    parameter int SEQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_W-1:0] seq_rx,
    input  logic             frame_stb,
    input  logic             slip,
    output logic             ev_ok,
    output logic             ev_bad
);
    logic [SEQ_W-1:0] ref_q;
    logic [SEQ_W-1:0] expect_w;
    logic             seeded_q;
    logic             match_w;

    assign expect_w = ref_q + 1'b1;
    assign match_w  = (seq_rx == expect_w);
    assign ev_ok    = frame_stb && seeded_q && match_w;
    assign ev_bad   = frame_stb && seeded_q && !match_w;

    // Reference follows good frames and coasts on the expected value after a miss
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= '0;
            seeded_q <= 1'b0;
        end else if (slip) begin
            seeded_q <= 1'b0;
        end else if (frame_stb) begin
            seeded_q <= 1'b1;
            ref_q    <= (seeded_q && !match_w) ? expect_w : seq_rx;
        end
    end

endmodule

// File: rtl/frm_lock_fsm.sv
module frm_lock_fsm
    import frm_pkg::*;
#(
    parameter int CONFIRM_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_ok,
    input  logic ev_bad,
    output logic lock_next,
    output logic locked,
    output logic slip
);
    localparam int CC_W = $clog2(CONFIRM_N + 1);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(CONFIRM_N - 1);

    lock_state_t state_q, state_d;
    logic [CC_W-1:0] conf_cnt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (ev_bad) state_d = ST_SUSPECT;
            end
            ST_SUSPECT: begin
                if (ev_bad)     state_d = ST_HUNT;
                else if (ev_ok) state_d = ST_LOCKED;
            end
            ST_HUNT: begin
                if (ev_ok) state_d = (CONFIRM_N == 1) ? ST_LOCKED : ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (ev_bad)                          state_d = ST_HUNT;
                else if (ev_ok && conf_cnt == CC_LAST) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Registered outputs: slip pulse and confirmation count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip     <= 1'b0;
            conf_cnt <= '0;
        end else begin
            slip <= ev_bad && (state_q != ST_LOCKED);
            if (ev_bad) begin
                conf_cnt <= '0;
            end else if (ev_ok && state_q == ST_HUNT) begin
                conf_cnt <= CC_W'(1);
            end else if (ev_ok && state_q == ST_CONFIRM) begin
                conf_cnt <= conf_cnt + 1'b1;
            end
        end
    end

    assign locked    = (state_q == ST_LOCKED) || (state_q == ST_SUSPECT);
    assign lock_next = (state_d == ST_LOCKED) || (state_d == ST_SUSPECT);

endmodule

// File: rtl/frm_align_tracker.sv
module frm_align_tracker
    import frm_pkg::*;
#(
    parameter int COLOR_BITS = 6,
    parameter int CONFIRM_N  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_in,
    output logic [3*COLOR_BITS-1:0] pix_rgb,
    output logic                    pix_vs,
    output logic                    pix_hs,
    output logic                    pix_de,
    output logic                    pix_valid,
    output logic                    par_err,
    output logic                    locked
);
    localparam int PIX_W   = 3 * COLOR_BITS;
    localparam int FRAME_W = PIX_W + OVH_BITS;

    logic [FRAME_W-1:0] frame_q;
    logic               frame_stb;
    logic               slip_w;
    logic               ev_ok_w;
    logic               ev_bad_w;
    logic               lock_next_w;
    logic               take_w;

    frm_slicer #(.FRAME_W(FRAME_W)) u_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .slip      (slip_w),
        .frame_q   (frame_q),
        .frame_stb (frame_stb)
    );

    frm_seq_check #(.SEQ_W(SEQ_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_rx    (frame_q[POS_F1:POS_F0]),
        .frame_stb (frame_stb),
        .slip      (slip_w),
        .ev_ok     (ev_ok_w),
        .ev_bad    (ev_bad_w)
    );

    frm_lock_fsm #(.CONFIRM_N(CONFIRM_N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_ok     (ev_ok_w),
        .ev_bad    (ev_bad_w),
        .lock_next (lock_next_w),
        .locked    (locked),
        .slip      (slip_w)
    );

    assign take_w = frame_stb && lock_next_w;

    // Output register: payload only in the pulse cycle, zero otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_rgb   <= '0;
            pix_vs    <= 1'b0;
            pix_hs    <= 1'b0;
            pix_de    <= 1'b0;
            par_err   <= 1'b0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= take_w;
            if (take_w) begin
                pix_rgb <= frame_q[FRAME_W-1:PIX_LSB];
                pix_vs  <= frame_q[POS_VS];
                pix_hs  <= frame_q[POS_HS];
                pix_de  <= frame_q[POS_DE];
                par_err <= ~(^frame_q);
            end else begin
                pix_rgb <= '0;
                pix_vs  <= 1'b0;
                pix_hs  <= 1'b0;
                pix_de  <= 1'b0;
                par_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/frm_align_checker.sv
module frm_align_checker #(
    parameter int PIX_W     = 18,
    parameter int CONFIRM_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             locked,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_rgb,
    input logic             pix_vs,
    input logic             pix_hs,
    input logic             pix_de,
    input logic             par_err,
    input logic             slip_w,
    input logic             ev_ok_w,
    input logic             ev_bad_w
);
    // Good steps seen since the last slip, saturating
    int ok_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ok_run <= 0;
        else if (slip_w)                ok_run <= 0;
        else if (ev_ok_w && ok_run < CONFIRM_N) ok_run <= ok_run + 1;
    end

    a_r9_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> locked);

    a_r9_zero_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_rgb == '0 && !pix_vs && !pix_hs && !pix_de && !par_err));

    a_r8_drop_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(ev_bad_w));

    a_r10_slip_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        slip_w |-> !locked);

    a_r10_slip_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        slip_w |=> !slip_w);

    a_r11_confirm_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (ok_run >= CONFIRM_N));

endmodule

bind frm_align_tracker frm_align_checker #(.PIX_W(PIX_W), .CONFIRM_N(CONFIRM_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .pix_valid (pix_valid),
    .pix_rgb   (pix_rgb),
    .pix_vs    (pix_vs),
    .pix_hs    (pix_hs),
    .pix_de    (pix_de),
    .par_err   (par_err),
    .slip_w    (slip_w),
    .ev_ok_w   (ev_ok_w),
    .ev_bad_w  (ev_bad_w)
);

// File: tb/frm_align_tracker_bench.sv
module frm_align_tracker_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, ser_in;
    logic [17:0] pix_rgb;
    logic        pix_vs, pix_hs, pix_de, pix_valid, par_err, locked;

    frm_align_tracker u_frm_align_tracker (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .pix_rgb(pix_rgb),
        .pix_vs(pix_vs), .pix_hs(pix_hs), .pix_de(pix_de),
        .pix_valid(pix_valid), .par_err(par_err), .locked(locked)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // Output capture
    logic [17:0] cap_pix [64];
    logic [2:0]  cap_ctl [64];
    logic        cap_pe  [64];
    int   cap_n;
    int   relock_idx;
    logic seen_unlock, prev_lock;

    always @(negedge clk) begin
        if (rst_n) begin
            if (locked && !prev_lock) relock_idx = cap_n;
            prev_lock = locked;
            if (!locked) seen_unlock = 1'b1;
            if (pix_valid && cap_n < 64) begin
                cap_pix[cap_n] = pix_rgb;
                cap_ctl[cap_n] = {pix_vs, pix_hs, pix_de};
                cap_pe[cap_n]  = par_err;
                cap_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] pay(input int i);
        return {6'(i * 5 + 1), 6'(i * 11 + 7), 6'(i)};
    endfunction

    function automatic logic [23:0] mk(input logic [17:0] p, input logic [2:0] c,
                                       input logic [1:0] f, input logic bad);
        logic [22:0] up;
        up = {p, c, f};
        return {up, (~(^up)) ^ bad};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; ser_in = 1'b0;
        cap_n = 0; relock_idx = -1; seen_unlock = 1'b0; prev_lock = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [23:0] w);
        for (int k = 23; k >= 0; k--) send_bit(w[k]);
    endtask

    task automatic flush();
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(locked == 1'b1, "R4", "locked after reset", int'(locked), 1);
        chk(pix_valid == 1'b0, "R9", "valid after reset", int'(pix_valid), 0);
        chk(pix_rgb == '0, "R9", "pixel after reset", int'(pix_rgb), 0);
    endtask

    task automatic t_aligned();
        do_reset();
        for (int i = 0; i < 10; i++) send_frame(mk(pay(i), 3'(i), 2'(i + 2), 1'b0));
        flush();
        chk(cap_n == 10, "R4", "frames out, first only seeds", cap_n, 10);
        for (int i = 0; i < 10; i++) begin
            chk(cap_pix[i] == pay(i), "R1", "pixel layout", int'(cap_pix[i]), int'(pay(i)));
            chk(cap_ctl[i] == 3'(i), "R2", "timing bits", int'(cap_ctl[i]), i % 8);
            chk(cap_pe[i] == 1'b0, "R5", "no parity error", int'(cap_pe[i]), 0);
        end
        chk(seen_unlock == 1'b0, "R3", "count wrap 3 to 0 keeps lock", int'(seen_unlock), 0);
    endtask

    task automatic t_parity();
        do_reset();
        for (int i = 0; i < 6; i++) send_frame(mk(pay(i), 3'(i), 2'(i), i == 3));
        flush();
        chk(cap_n == 6, "R6", "all frames output", cap_n, 6);
        for (int i = 0; i < 6; i++)
            chk(cap_pe[i] == (i == 3), "R5", "parity flag", int'(cap_pe[i]), int'(i == 3));
        chk(seen_unlock == 1'b0, "R6", "lock kept on parity error", int'(seen_unlock), 0);
    endtask

    task automatic t_glitch();
        do_reset();
        for (int i = 0; i < 10; i++)
            send_frame(mk(pay(i), 3'(i), (i == 4) ? 2'd3 : 2'(i), 1'b0));
        flush();
        chk(seen_unlock == 1'b0, "R7", "single miss keeps lock", int'(seen_unlock), 0);
        chk(cap_n == 10, "R7", "glitch frame still output", cap_n, 10);
        for (int i = 0; i < 10; i++)
            chk(cap_pix[i] == pay(i), "R7", "pixel order", int'(cap_pix[i]), int'(pay(i)));
    endtask

    task automatic t_double_miss();
        do_reset();
        for (int i = 0; i < 4; i++) send_frame(mk(pay(i), 3'(i), 2'(i), 1'b0));
        send_frame(mk(pay(4), 3'd4, 2'd2, 1'b0));
        send_frame(mk(pay(5), 3'd5, 2'd3, 1'b0));
        for (int i = 6; i < 9; i++) send_frame(mk(pay(i), 3'(i), 2'(i), 1'b0));
        flush();
        chk(cap_n == 5, "R8", "second miss not output", cap_n, 5);
        chk(seen_unlock == 1'b1, "R8", "lock dropped", int'(seen_unlock), 1);
        chk(locked == 1'b0, "R8", "still hunting", int'(locked), 0);
        chk(pix_valid == 1'b0 && pix_rgb == '0, "R9", "outputs zero while unlocked",
            int'(pix_rgb), 0);
    endtask

    task automatic t_bit_insert();
        do_reset();
        for (int i = 0; i < 6; i++) send_frame(mk(pay(i), 3'd0, 2'(i), 1'b0));
        send_bit(1'b0);
        for (int i = 6; i < 16; i++) send_frame(mk(pay(i), 3'd0, 2'(i), 1'b0));
        flush();
        chk(seen_unlock == 1'b1, "R10", "lock lost after inserted bit", int'(seen_unlock), 1);
        chk(relock_idx == 7, "R11", "output index at relock", relock_idx, 7);
        chk(locked == 1'b1, "R10", "relocked after one slip", int'(locked), 1);
        chk(cap_n >= 11, "R11", "frames after relock", cap_n, 11);
        for (int j = 0; j < 4; j++)
            chk(cap_pix[7 + j] == pay(12 + j), "R11", "frame after relock",
                int'(cap_pix[7 + j][5:0]), 12 + j);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ser_in = 1'b0;
        t_reset_state();
        t_aligned();
        t_parity();
        t_glitch();
        t_double_miss();
        t_bit_insert();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule